// File: doc/BRIEF.md
# I2S Bit and Frame Clock Generator

This block produces the serial bit clock and the left/right frame clock for an I2S-style audio port from the master clock it runs on. In master mode it divides the master clock by 2 or 4 to form the bit clock. It then counts 32, 64 or 128 bit-clock periods per frame to form the frame clock. Both outputs have a programmable polarity. The bit clock can be parked whenever the port has nothing to move.

It also gives transmit and receive shifters two single-cycle strobes in the master-clock domain. The launch strobe marks the bit-clock edge on which data changes. The sample strobe marks the opposite edge.

In slave mode the external bit and frame clocks pass straight to the outputs. The strobes are then derived from synchronized edges of the external bit clock. Ratio changes made while the clocks run are held back until the current frame ends.

Top module: `i2s_clkgen`

## Requirements
- R1: In master mode with enable set, bclk_o has a period of 2 master-clock cycles when div4_i is 0 and 4 cycles when div4_i is 1. The first bit-clock transition after enable rises comes on the first clock edge (divide by 2) or the second (divide by 4).
- R2: A frame spans N bit-clock periods, where frame_sel_i of 0, 1, 2 and 3 selects N = 32, 64, 128 and 128. The frame clock changes level after every N/2 launch edges, giving a 50% duty cycle.
- R3: launch_o and sample_o are registered pulses one master-clock cycle wide. In master mode launch_o is high in exactly the cycle in which bclk_o has just made its launch transition, and sample_o in the cycle after the opposite transition. The two are never high together.
- R4: With bclk_inv_i = 0 the launch transition is the falling edge of bclk_o and the idle level is low. With bclk_inv_i = 1 the launch transition is the rising edge and the idle level is high.
- R5: With lr_inv_i = 0, lrclk_o is low for the first half of every frame, which is the left word, starting from enable. With lr_inv_i = 1 it is high for that half.
- R6: A change of div4_i or frame_sel_i while the master clocks run takes effect only after the last launch edge of the current frame. The next frame starts from a fresh low bit-clock phase.
- R7: In master mode with free_run_i = 0 and busy_i = 0, the bit clock completes any high phase in progress with its launch transition. It then holds the idle level with no strobes and a frozen frame clock. It restarts when busy_i or free_run_i is set. With free_run_i = 1 it runs whatever busy_i is.
- R8: While en_i is 0 (and from reset), bclk_o sits at its idle level, lrclk_o equals lr_inv_i and no strobes are produced. Re-enabling restarts at the beginning of a left word.
- R9: In slave mode (master_i = 0), bclk_o and lrclk_o follow ext_bclk_i and ext_lrclk_i combinationally. Each external bit-clock edge yields one strobe on the third falling edge of the test clock after the change, launch_o or sample_o as chosen per R4 polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global enable of the interface |
| master_i | input | 1 | 1: generate clocks, 0: follow external clocks |
| div4_i | input | 1 | Master-to-bit-clock ratio, 0: /2, 1: /4 |
| frame_sel_i | input | 2 | Bit clocks per frame: 0:32, 1:64, 2/3:128 |
| bclk_inv_i | input | 1 | Bit-clock polarity, 1 launches on rising edge |
| lr_inv_i | input | 1 | Frame-clock polarity, 1 makes the left word high |
| free_run_i | input | 1 | Keep the bit clock running when idle |
| busy_i | input | 1 | Data pending; lets a gated bit clock run |
| ext_bclk_i | input | 1 | External bit clock (slave mode) |
| ext_lrclk_i | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame clock |
| launch_o | output | 1 | Strobe on the data-launch bit-clock edge |
| sample_o | output | 1 | Strobe on the data-sample bit-clock edge |

## Verification
A half-period counter that wraps wrongly shows up at once as a bclk_o level one cycle off the arithmetic schedule, within the first bit period after enable. A mistake in the bit counter, a wrong mid-frame toggle, or a ratio applied too early shows as an lrclk_o level off schedule. That error appears at the first half-frame or frame boundary, at most 512 master cycles in. Strobe errors appear on the very cycle of the bit-clock transition they belong to. In slave mode a wrong synchronizer depth moves the strobe off the third sample of each external phase.

// File: rtl/i2s_clk_pkg.sv
package i2s_clk_pkg;
  parameter int unsigned MAX_BITS = 128;
  localparam int unsigned BIT_W = $clog2(MAX_BITS);

  typedef enum logic [1:0] {FR_32 = 2'd0, FR_64 = 2'd1, FR_128 = 2'd2, FR_128B = 2'd3} frame_sel_e;

  typedef struct packed {
    logic       div4;
    frame_sel_e fsel;
  } ratio_t;

  // index of the last bit-clock period in a frame
  function automatic logic [BIT_W-1:0] last_bit(frame_sel_e sel);
    case (sel)
      FR_32:   last_bit = BIT_W'(31);
      FR_64:   last_bit = BIT_W'(63);
      default: last_bit = BIT_W'(MAX_BITS - 1);
    endcase
  endfunction
endpackage

// File: rtl/i2s_bclk_div.sv
module i2s_bclk_div #(
  parameter int unsigned HALF_MAX = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic gate_i,
  input  logic div4_i,
  output logic bclk_q_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned HW = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;

  logic [HW-1:0] half_cnt;
  logic [HW-1:0] half_last;
  logic          at_term;

  assign half_last = div4_i ? HW'(HALF_MAX - 1) : '0;
  assign at_term   = (half_cnt == half_last);
  assign rise_o    = run_i && at_term && !bclk_q_o && gate_i;
  assign fall_o    = run_i && at_term && bclk_q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_cnt <= '0;
      bclk_q_o <= 1'b0;
    end else if (!run_i) begin
      half_cnt <= '0;
      bclk_q_o <= 1'b0;
    end else if (!bclk_q_o && !gate_i) begin
      half_cnt <= '0;   // parked at idle level
    end else if (at_term) begin
      half_cnt <= '0;
      bclk_q_o <= ~bclk_q_o;
    end else begin
      half_cnt <= half_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2s_frame_div.sv
module i2s_frame_div
  import i2s_clk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       step_i,
  input  frame_sel_e fsel_i,
  output logic       lr_q_o,
  output logic       frame_end_o
);
  logic [BIT_W-1:0] bit_cnt;
  logic [BIT_W-1:0] last;
  logic [BIT_W-1:0] mid;

  assign last        = last_bit(fsel_i);
  assign mid         = last >> 1;
  assign frame_end_o = step_i && (bit_cnt == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt <= '0;
      lr_q_o  <= 1'b0;
    end else if (!run_i) begin
      bit_cnt <= '0;
      lr_q_o  <= 1'b0;
    end else if (step_i) begin
      bit_cnt <= frame_end_o ? '0 : bit_cnt + 1'b1;
      if (bit_cnt == mid || bit_cnt == last) lr_q_o <= ~lr_q_o;
    end
  end
endmodule

// File: rtl/i2s_slave_edge.sv
module i2s_slave_edge #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  input  logic inv_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC:0] sh;
  logic          cur, prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh <= '0;
    else         sh <= {sh[SYNC-1:0], ext_i};
  end

  assign cur    = sh[SYNC-1] ^ inv_i;
  assign prev   = sh[SYNC] ^ inv_i;
  assign rise_o = cur & ~prev;
  assign fall_o = prev & ~cur;
endmodule

// File: rtl/i2s_clkgen.sv
module i2s_clkgen
  import i2s_clk_pkg::*;
#(
  parameter int unsigned SYNC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       master_i,
  input  logic       div4_i,
  input  logic [1:0] frame_sel_i,
  input  logic       bclk_inv_i,
  input  logic       lr_inv_i,
  input  logic       free_run_i,
  input  logic       busy_i,
  input  logic       ext_bclk_i,
  input  logic       ext_lrclk_i,
  output logic       bclk_o,
  output logic       lrclk_o,
  output logic       launch_o,
  output logic       sample_o
);
  logic   run, gate;
  ratio_t act;
  logic   m_bclk, m_rise, m_fall, m_lr, frame_end;
  logic   s_rise, s_fall;

  assign run  = en_i && master_i;
  assign gate = free_run_i || busy_i;

  // ratios are shadowed and only reloaded at a frame boundary while running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 act <= '{div4: 1'b0, fsel: FR_32};
    else if (!run || frame_end)  act <= '{div4: div4_i, fsel: frame_sel_e'(frame_sel_i)};
  end

  i2s_bclk_div u_bdiv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .gate_i  (gate),
    .div4_i  (act.div4),
    .bclk_q_o(m_bclk),
    .rise_o  (m_rise),
    .fall_o  (m_fall)
  );

  i2s_frame_div u_fdiv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .step_i     (m_fall),
    .fsel_i     (act.fsel),
    .lr_q_o     (m_lr),
    .frame_end_o(frame_end)
  );

  i2s_slave_edge #(.SYNC(SYNC)) u_sedge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ext_i (ext_bclk_i),
    .inv_i (bclk_inv_i),
    .rise_o(s_rise),
    .fall_o(s_fall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      launch_o <= 1'b0;
      sample_o <= 1'b0;
    end else begin
      launch_o <= en_i && (master_i ? m_fall : s_fall);
      sample_o <= en_i && (master_i ? m_rise : s_rise);
    end
  end

  assign bclk_o  = master_i ? (m_bclk ^ bclk_inv_i) : ext_bclk_i;
  assign lrclk_o = master_i ? (m_lr ^ lr_inv_i) : ext_lrclk_i;
endmodule

// File: rtl/i2s_clkgen_chk.sv
module i2s_clkgen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic master_i,
  input logic bclk_inv_i,
  input logic lr_inv_i,
  input logic free_run_i,
  input logic busy_i,
  input logic bclk_o,
  input logic lrclk_o,
  input logic launch_o,
  input logic sample_o
);
  a_r3_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(launch_o && sample_o));

  a_r8_no_strobe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!launch_o && !sample_o));

  // R4: after a launch strobe the bit clock sits at its idle level
  a_r4_launch_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && $stable(bclk_inv_i) && launch_o) |-> (bclk_o == bclk_inv_i));

  a_r3_launch_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && $stable(bclk_inv_i) && launch_o) |-> (bclk_o != $past(bclk_o)));

  a_r2_lr_on_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && $past(en_i) && $stable(lr_inv_i) &&
     (lrclk_o != $past(lrclk_o))) |-> launch_o);

  a_r7_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && master_i && !free_run_i && !busy_i && $stable(bclk_inv_i) &&
     (bclk_o == bclk_inv_i)) |=> !sample_o);
endmodule

bind i2s_clkgen i2s_clkgen_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .master_i  (master_i),
  .bclk_inv_i(bclk_inv_i),
  .lr_inv_i  (lr_inv_i),
  .free_run_i(free_run_i),
  .busy_i    (busy_i),
  .bclk_o    (bclk_o),
  .lrclk_o   (lrclk_o),
  .launch_o  (launch_o),
  .sample_o  (sample_o)
);

// File: tb/sim_i2s_clkgen.sv
module sim_i2s_clkgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, master = 1'b1, div4 = 1'b0;
  logic [1:0] fsel = 2'd0;
  logic       binv = 1'b0, lrinv = 1'b0, free_run = 1'b1, busy = 1'b0;
  logic       ext_b = 1'b0, ext_lr = 1'b0;
  logic       bclk, lrclk, launch, sample;
  int         vecs = 0, errs = 0;

  always #2 clk = ~clk;

  i2s_clkgen u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .master_i(master), .div4_i(div4),
    .frame_sel_i(fsel), .bclk_inv_i(binv), .lr_inv_i(lrinv), .free_run_i(free_run),
    .busy_i(busy), .ext_bclk_i(ext_b), .ext_lrclk_i(ext_lr),
    .bclk_o(bclk), .lrclk_o(lrclk), .launch_o(launch), .sample_o(sample)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // expected outputs k edges after a fresh start, half period h, n bits per frame
  task automatic check_seg(input int h, input int n, input int kfrom, input int kto, input string req);
    for (int k = kfrom; k <= kto; k++) begin
      int t, falls;
      bit tog;
      @(posedge clk); @(negedge clk);
      t     = k / h;
      falls = t / 2;
      tog   = (k % h) == 0;
      chk(req, "bclk", bclk, (t % 2) ^ binv);
      chk(req, "lrclk", lrclk, (((falls % n) >= n / 2) ? 1 : 0) ^ lrinv);
      chk(req, "launch", launch, (tog && t % 2 == 0 && t > 0) ? 1 : 0);
      chk(req, "sample", sample, (tog && t % 2 == 1) ? 1 : 0);
    end
  endtask

  task automatic check_idle(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(req, "idle bclk", bclk, binv);
      chk(req, "idle lrclk", lrclk, lrinv);
      chk(req, "idle launch", launch, 0);
      chk(req, "idle sample", sample, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int lr_hold, cnt;
    repeat (3) @(negedge clk);
    check_idle(1, "R8 reset");
    rst_n = 1'b1;
    check_idle(2, "R8");

    // R1 R2 R3 R4 R5 sweep over ratios and polarities, restart each time (R8)
    for (int c = 0; c < 32; c++) begin
      int h, n;
      @(negedge clk);
      en = 1'b0;
      div4 = c[0]; fsel = c[2:1]; binv = c[3]; lrinv = c[4];
      check_idle(2, "R8");
      h = div4 ? 2 : 1;
      n = (fsel == 2'd0) ? 32 : (fsel == 2'd1) ? 64 : 128;
      en = 1'b1;
      check_seg(h, n, 1, 4 * n * h + 3, "R1 R2 R3 R4 R5");
    end

    // R6: ratio change mid-frame waits for the frame boundary
    @(negedge clk);
    en = 1'b0; div4 = 1'b0; fsel = 2'd0; binv = 1'b0; lrinv = 1'b0;
    check_idle(2, "R8");
    en = 1'b1;
    check_seg(1, 32, 1, 10, "R6 before");
    div4 = 1'b1; fsel = 2'd1;
    check_seg(1, 32, 11, 64, "R6 old ratio held");
    check_seg(2, 64, 1, 300, "R6 new ratio");

    // R7: idle gating
    @(negedge clk);
    en = 1'b0; div4 = 1'b0; fsel = 2'd0; free_run = 1'b0; busy = 1'b0;
    check_idle(2, "R8");
    en = 1'b1;
    check_idle(20, "R7 parked");
    busy = 1'b1;
    check_seg(1, 32, 1, 41, "R7 busy run");
    busy = 1'b0;
    @(negedge clk);
    chk("R7", "finish high phase bclk", bclk, 0);
    chk("R7", "finish high phase launch", launch, 1);
    lr_hold = lrclk;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R7", "gated bclk", bclk, 0);
      chk("R7", "gated lrclk", lrclk, lr_hold);
      chk("R7", "gated strobe", launch | sample, 0);
    end
    free_run = 1'b1;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cnt += sample;
    end
    chk("R7", "free-run samples", cnt, 10);

    // R9: slave pass-through and synchronized strobes
    for (int pol = 0; pol < 2; pol++) begin
      @(negedge clk);
      en = 1'b0; free_run = 1'b1; master = 1'b0; ext_b = 1'b0; ext_lr = 1'b0;
      binv = pol[0];
      repeat (4) @(negedge clk);
      chk("R9", "slave disabled strobe", launch | sample, 0);
      en = 1'b1;
      for (int p = 0; p < 16; p++) begin
        bit v;
        v = (p % 2 == 0);
        ext_b = v;
        if (p % 8 == 0) ext_lr = ~ext_lr;
        #0;
        for (int i = 1; i <= 3; i++) begin
          @(negedge clk);
          chk("R9", "pass bclk", bclk, ext_b);
          chk("R9", "pass lrclk", lrclk, ext_lr);
          chk("R9", "slave launch", launch, (i == 3 && ((v == 1'b0) ^ binv)) ? 1 : 0);
          chk("R9", "slave sample", sample, (i == 3 && ((v == 1'b1) ^ binv)) ? 1 : 0);
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule